// File: doc/BRIEF.md
# Video Source Selection Controller

This block is the digital control logic of a multi-input video switch. A register file supplies a 4-bit source code, a comb-enable bit and two 3-bit selects for auxiliary composite outputs. A colour-standard identifier supplies a valid strobe, a standard identifier and a "combable" flag. Burst measurement hardware supplies a burst amplitude for the luma/composite pin and for the chroma pin of each of the two dual-purpose inputs (input 3 and input 4). The controller decides which source drives the main luminance/chrominance path, what is fed to an external comb filter, whether the reference subcarrier for that filter is on, and reports the comb and Y/C status in a status byte.

Static codes map straight to a source. Two automatic codes let the block choose the composite, Y/C or comb-return path from the burst measurements once the standard identifier reports a valid result. Each automatic decision is taken again whenever the source code, the comb enable or the identified standard changes. Between those events it is held, whatever the amplitudes do. Two auxiliary outputs get independent, registered selects.

Top module: `vsel_src_ctrl`

## Requirements
- R1: With comb enable low, static codes select the main source one clock after they are applied. `main_src` uses this encoding: 0 internal, 1 external 1, 2 external 2, 3 composite 3, 4 Y3/C3, 5 composite 4, 6 Y4/C4, 7 comb returns. The code map is 0000/0001→0, 0010→1, 0011→2, 0100→3, 0101→4, 0110→5, 0111→6.
- R2: Codes 1000–1011, 1101 and 1111 select the internal source (0).
- R3: `comb_feed` carries the source of the code in the auxiliary encoding of R10: the composite of the input, or Y+C for a Y/C source. `ref_en` equals comb enable, delayed by one clock.
- R4: For a static code, the main path is 7 (comb returns) when comb enable is high, `std_valid` is high and `std_combable` is high. Otherwise the main path is the direct source.
- R5: The main path is never 7 unless comb enable, `std_valid` and `std_combable` were all high one clock earlier.
- R6: Auto Y/C (code 1100 for input 3, code 1110 for input 4, comb enable low) selects the Y/C source when the chroma-pin amplitude is strictly greater than the luma-pin amplitude. Otherwise it selects the composite source, including when the two are equal. `stat_byte` bit 6 is 1 when the main path is 4 or 6.
- R7: Auto comb (the same codes with comb enable high) selects Y/C when the chroma amplitude is at least BURST_THR. Otherwise it selects the comb returns when the luma amplitude is at least BURST_THR and the standard is combable. In all other cases it selects the composite source. The comb filter is fed the composite source unless Y/C was chosen.
- R8: An automatic decision is taken at the first clock with `std_valid` high after a change of source code, comb enable or `std_id`. The main path reflects it one clock later. Amplitude changes alone have no effect.
- R9: `stat_byte` bit 5 is 1 exactly when the main path is 7. Bits 7 and 4–0 are 0.
- R10: Each auxiliary select is registered independently, with one clock of latency. Values 000/001 give 000 (internal), and 010–111 pass through (2 ext 1, 3 ext 2, 4 composite 3, 5 Y3+C3, 6 composite 4, 7 Y4+C4).
- R11: In reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_code | input | 4 | Main-path source code |
| comb_en | input | 1 | Comb filter enable |
| std_valid | input | 1 | Standard identification result valid |
| std_combable | input | 1 | Identified standard can be combed |
| std_id | input | STD_W | Identified standard |
| amp_y3 | input | AMP_W | Burst amplitude on input 3 luma/composite pin |
| amp_c3 | input | AMP_W | Burst amplitude on input 3 chroma pin |
| amp_y4 | input | AMP_W | Burst amplitude on input 4 luma/composite pin |
| amp_c4 | input | AMP_W | Burst amplitude on input 4 chroma pin |
| txt_sel | input | 3 | Auxiliary output A select |
| pip_sel | input | 3 | Auxiliary output B select |
| main_src | output | 3 | Main-path source (R1 encoding) |
| comb_feed | output | 3 | Source fed to comb filter (R10 encoding) |
| ref_en | output | 1 | Reference subcarrier output enable |
| stat_byte | output | 8 | Status: bit 5 comb in use, bit 6 Y/C path |
| txt_out | output | 3 | Auxiliary output A selection |
| pip_out | output | 3 | Auxiliary output B selection |

## Verification
Static selections, the status byte, `ref_en` and both auxiliary outputs are due one clock after their inputs, so the bench samples them just after the first rising edge. An automatic decision takes three edges from the code write: one to see the change, one to decide on valid identification, and one to register the output. The bench therefore samples automatic results after three edges, and first parks the code on a static value to force a fresh evaluation. The hold checks wait five edges after changing only amplitudes, or with identification not valid, and then confirm that the output has not moved.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [2:0] {
        SRC_INT  = 3'd0,
        SRC_EXT1 = 3'd1,
        SRC_EXT2 = 3'd2,
        SRC_CV3  = 3'd3,
        SRC_YC3  = 3'd4,
        SRC_CV4  = 3'd5,
        SRC_YC4  = 3'd6,
        SRC_COMB = 3'd7
    } main_src_e;

    typedef enum logic [1:0] {
        DEC_CV   = 2'd0,
        DEC_YC   = 2'd1,
        DEC_COMB = 2'd2
    } auto_dec_e;

    localparam int STAT_COMB_BIT = 5;
    localparam int STAT_YC_BIT   = 6;

    // Auxiliary-style code for a direct source; comb and internal give 0.
    function automatic logic [2:0] feed_of(main_src_e s);
        if (s == SRC_INT || s == SRC_COMB)
            return 3'd0;
        return 3'(s) + 3'd1;
    endfunction

endpackage

// File: rtl/vsel_code_dec.sv
module vsel_code_dec
    import vsel_pkg::*;
(
    input  logic [3:0] code_i,
    output main_src_e  direct_o,
    output logic       is_auto_o,
    output logic       auto_in4_o
);
    always_comb begin
        direct_o   = SRC_INT;
        is_auto_o  = 1'b0;
        auto_in4_o = code_i[1];
        case (code_i)
            4'b0010: direct_o = SRC_EXT1;
            4'b0011: direct_o = SRC_EXT2;
            4'b0100: direct_o = SRC_CV3;
            4'b0101: direct_o = SRC_YC3;
            4'b0110: direct_o = SRC_CV4;
            4'b0111: direct_o = SRC_YC4;
            4'b1100,
            4'b1110: is_auto_o = 1'b1;
            default: direct_o = SRC_INT;
        endcase
    end
endmodule

// File: rtl/vsel_auto_judge.sv
module vsel_auto_judge
    import vsel_pkg::*;
#(
    parameter int AMP_W     = 6,
    parameter int STD_W     = 2,
    parameter int BURST_THR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       code_i,
    input  logic             comb_en_i,
    input  logic [STD_W-1:0] std_id_i,
    input  logic             std_valid_i,
    input  logic             std_combable_i,
    input  logic [AMP_W-1:0] amp_y_i,
    input  logic [AMP_W-1:0] amp_c_i,
    output auto_dec_e        dec_o
);
    localparam logic [AMP_W-1:0] THR = AMP_W'(BURST_THR);

    typedef struct packed {
        logic [3:0]       code;
        logic             comb;
        logic [STD_W-1:0] std;
        logic             pend;
        auto_dec_e        dec;
    } judge_st_t;

    judge_st_t st_d, st_q;
    logic      trig;
    auto_dec_e verdict;

    always_comb begin
        trig = (code_i != st_q.code) || (comb_en_i != st_q.comb) ||
               (std_id_i != st_q.std);
        if (comb_en_i) begin
            if (amp_c_i >= THR)
                verdict = DEC_YC;
            else if (amp_y_i >= THR && std_combable_i)
                verdict = DEC_COMB;
            else
                verdict = DEC_CV;
        end else begin
            verdict = (amp_c_i > amp_y_i) ? DEC_YC : DEC_CV;
        end

        st_d      = st_q;
        st_d.code = code_i;
        st_d.comb = comb_en_i;
        st_d.std  = std_id_i;
        st_d.pend = trig || (st_q.pend && !std_valid_i);
        if (!trig && st_q.pend && std_valid_i)
            st_d.dec = verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= '0;
            st_q.comb <= 1'b0;
            st_q.std  <= '0;
            st_q.pend <= 1'b1;
            st_q.dec  <= DEC_CV;
        end else begin
            st_q <= st_d;
        end
    end

    assign dec_o = st_q.dec;
endmodule

// File: rtl/vsel_aux_reg.sv
module vsel_aux_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic [SEL_W-1:0] sel_o
);
    logic [SEL_W-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = (sel_i == SEL_W'(1)) ? '0 : sel_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_o = sel_q;
endmodule

// File: rtl/vsel_src_ctrl.sv
module vsel_src_ctrl
    import vsel_pkg::*;
#(
    parameter int AMP_W     = 6,
    parameter int STD_W     = 2,
    parameter int BURST_THR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       src_code,
    input  logic             comb_en,
    input  logic             std_valid,
    input  logic             std_combable,
    input  logic [STD_W-1:0] std_id,
    input  logic [AMP_W-1:0] amp_y3,
    input  logic [AMP_W-1:0] amp_c3,
    input  logic [AMP_W-1:0] amp_y4,
    input  logic [AMP_W-1:0] amp_c4,
    input  logic [2:0]       txt_sel,
    input  logic [2:0]       pip_sel,
    output logic [2:0]       main_src,
    output logic [2:0]       comb_feed,
    output logic             ref_en,
    output logic [7:0]       stat_byte,
    output logic [2:0]       txt_out,
    output logic [2:0]       pip_out
);
    localparam int N_AUX = 2;

    typedef struct packed {
        main_src_e  src;
        logic [2:0] feed;
        logic       ref_on;
        logic [7:0] stat;
    } out_st_t;

    out_st_t    out_d, out_q;
    main_src_e  direct;
    logic       is_auto, auto_in4;
    auto_dec_e  dec;
    logic [AMP_W-1:0] amp_y_sel, amp_c_sel;
    logic [2:0] aux_in  [N_AUX];
    logic [2:0] aux_out [N_AUX];

    vsel_code_dec u_dec (
        .code_i     (src_code),
        .direct_o   (direct),
        .is_auto_o  (is_auto),
        .auto_in4_o (auto_in4)
    );

    assign amp_y_sel = auto_in4 ? amp_y4 : amp_y3;
    assign amp_c_sel = auto_in4 ? amp_c4 : amp_c3;

    vsel_auto_judge #(
        .AMP_W     (AMP_W),
        .STD_W     (STD_W),
        .BURST_THR (BURST_THR)
    ) u_judge (
        .clk            (clk),
        .rst_n          (rst_n),
        .code_i         (src_code),
        .comb_en_i      (comb_en),
        .std_id_i       (std_id),
        .std_valid_i    (std_valid),
        .std_combable_i (std_combable),
        .amp_y_i        (amp_y_sel),
        .amp_c_i        (amp_c_sel),
        .dec_o          (dec)
    );

    assign aux_in[0] = txt_sel;
    assign aux_in[1] = pip_sel;

    for (genvar g = 0; g < N_AUX; g++) begin : g_aux
        vsel_aux_reg #(.SEL_W(3)) u_aux (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (aux_in[g]),
            .sel_o (aux_out[g])
        );
    end

    assign txt_out = aux_out[0];
    assign pip_out = aux_out[1];

    always_comb begin
        logic      comb_ok;
        main_src_e cv_src, yc_src, pick;
        comb_ok = comb_en && std_valid && std_combable;
        cv_src  = auto_in4 ? SRC_CV4 : SRC_CV3;
        yc_src  = auto_in4 ? SRC_YC4 : SRC_YC3;

        out_d        = out_q;
        out_d.ref_on = comb_en;
        if (!is_auto) begin
            out_d.feed = feed_of(direct);
            pick       = comb_ok ? SRC_COMB : direct;
        end else begin
            case (dec)
                DEC_YC: begin
                    out_d.feed = feed_of(yc_src);
                    pick       = yc_src;
                end
                DEC_COMB: begin
                    out_d.feed = feed_of(cv_src);
                    pick       = comb_ok ? SRC_COMB : cv_src;
                end
                default: begin
                    out_d.feed = feed_of(cv_src);
                    pick       = cv_src;
                end
            endcase
        end
        out_d.src                = pick;
        out_d.stat               = '0;
        out_d.stat[STAT_COMB_BIT] = (pick == SRC_COMB);
        out_d.stat[STAT_YC_BIT]   = (pick == SRC_YC3) || (pick == SRC_YC4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.src    <= SRC_INT;
            out_q.feed   <= '0;
            out_q.ref_on <= 1'b0;
            out_q.stat   <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign main_src  = out_q.src;
    assign comb_feed = out_q.feed;
    assign ref_en    = out_q.ref_on;
    assign stat_byte = out_q.stat;
endmodule

// File: rtl/vsel_src_ctrl_chk.sv
module vsel_src_ctrl_chk #(
    parameter int AMP_W = 6,
    parameter int STD_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       src_code,
    input logic             comb_en,
    input logic             std_valid,
    input logic             std_combable,
    input logic [2:0]       txt_sel,
    input logic [2:0]       pip_sel,
    input logic [2:0]       main_src,
    input logic             ref_en,
    input logic [7:0]       stat_byte,
    input logic [2:0]       txt_out,
    input logic [2:0]       pip_out
);
    logic arm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    AST_STATIC_EXT1: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        ($past(src_code) == 4'b0010 && !$past(comb_en)) |-> main_src == 3'd1); // R1
    AST_UNUSED_INT: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        ($past(src_code) inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd13, 4'd15} && !$past(comb_en))
        |-> main_src == 3'd0); // R2
    AST_REF_TRACKS: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        ref_en == $past(comb_en)); // R3
    AST_COMB_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        main_src == 3'd7 |-> $past(comb_en && std_valid && std_combable)); // R5
    AST_COMB_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        stat_byte[5] == (main_src == 3'd7)); // R9
    AST_TXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        txt_out == (($past(txt_sel) == 3'd1) ? 3'd0 : $past(txt_sel))); // R10
    AST_PIP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n || !arm_q)
        pip_out == (($past(pip_sel) == 3'd1) ? 3'd0 : $past(pip_sel))); // R10
endmodule

bind vsel_src_ctrl vsel_src_ctrl_chk #(.AMP_W(AMP_W), .STD_W(STD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_code     (src_code),
    .comb_en      (comb_en),
    .std_valid    (std_valid),
    .std_combable (std_combable),
    .txt_sel      (txt_sel),
    .pip_sel      (pip_sel),
    .main_src     (main_src),
    .ref_en       (ref_en),
    .stat_byte    (stat_byte),
    .txt_out      (txt_out),
    .pip_out      (pip_out)
);

// File: tb/sim_vsel_src_ctrl.sv
module sim_vsel_src_ctrl;
    localparam int AMP_W = 6;
    localparam int STD_W = 2;
    localparam int THR   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [3:0]       src_code = '0;
    logic             comb_en = 1'b0;
    logic             std_valid = 1'b0;
    logic             std_combable = 1'b0;
    logic [STD_W-1:0] std_id = '0;
    logic [AMP_W-1:0] amp_y3 = '0, amp_c3 = '0, amp_y4 = '0, amp_c4 = '0;
    logic [2:0]       txt_sel = '0, pip_sel = '0;
    logic [2:0]       main_src, comb_feed, txt_out, pip_out;
    logic             ref_en;
    logic [7:0]       stat_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vsel_src_ctrl #(.AMP_W(AMP_W), .STD_W(STD_W), .BURST_THR(THR)) u0 (
        .clk(clk), .rst_n(rst_n), .src_code(src_code), .comb_en(comb_en),
        .std_valid(std_valid), .std_combable(std_combable), .std_id(std_id),
        .amp_y3(amp_y3), .amp_c3(amp_c3), .amp_y4(amp_y4), .amp_c4(amp_c4),
        .txt_sel(txt_sel), .pip_sel(pip_sel), .main_src(main_src),
        .comb_feed(comb_feed), .ref_en(ref_en), .stat_byte(stat_byte),
        .txt_out(txt_out), .pip_out(pip_out)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int feed_exp(int s);
        return (s == 0 || s == 7) ? 0 : s + 1;
    endfunction

    function automatic int stat_exp(int s);
        return ((s == 7) ? 32 : 0) + ((s == 4 || s == 6) ? 64 : 0);
    endfunction

    function automatic int direct_exp(int code);
        case (code)
            2: return 1;  3: return 2;  4: return 3;
            5: return 4;  6: return 5;  7: return 6;
            default: return 0;
        endcase
    endfunction

    task automatic check_path(string req, int s, int f);
        chk({req, " main"}, int'(main_src), s);
        chk({req, " feed"}, int'(comb_feed), f);
        chk({req, " stat"}, int'(stat_byte), stat_exp(s));
    endtask

    // Automatic case: fresh evaluation, result due three edges after the write.
    task automatic auto_case(string req, int in4, int cen, int ay, int ac, int cb);
        int cv, yc, s, f;
        @(negedge clk);
        src_code = 4'b0000;
        @(negedge clk);
        src_code = in4 ? 4'b1110 : 4'b1100;
        comb_en = cen[0]; std_valid = 1'b1; std_combable = cb[0];
        if (in4) begin
            amp_y4 = AMP_W'(ay); amp_c4 = AMP_W'(ac); amp_y3 = AMP_W'(ac); amp_c3 = AMP_W'(ay);
        end else begin
            amp_y3 = AMP_W'(ay); amp_c3 = AMP_W'(ac); amp_y4 = AMP_W'(ac); amp_c4 = AMP_W'(ay);
        end
        repeat (3) @(posedge clk);
        #1;
        cv = in4 ? 5 : 3;
        yc = in4 ? 6 : 4;
        if (cen != 0) begin
            if (ac >= THR)                 s = yc;
            else if (ay >= THR && cb != 0) s = 7;
            else                           s = cv;
        end else begin
            s = (ac > ay) ? yc : cv;
        end
        f = (s == yc) ? yc + 1 : cv + 1;
        check_path(req, s, f);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check_path("R11", 0, 0);
        chk("R11 ref", int'(ref_en), 0);
        chk("R11 txt", int'(txt_out), 0);
        chk("R11 pip", int'(pip_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5: static codes across comb enable and identification
        for (int code = 0; code < 16; code++) begin
            if (code == 12 || code == 14) continue;
            for (int cen = 0; cen < 2; cen++) begin
                for (int q = 0; q < 4; q++) begin
                    int d, s;
                    @(negedge clk);
                    src_code = 4'(code); comb_en = cen[0];
                    std_valid = q[1]; std_combable = q[0];
                    @(posedge clk);
                    #1;
                    d = direct_exp(code);
                    s = (cen == 1 && q == 3) ? 7 : d;
                    if (code >= 8)      check_path("R2", s, feed_exp(d));
                    else if (s == 7)    check_path("R4", s, feed_exp(d));
                    else if (cen == 1)  check_path("R5", s, feed_exp(d));
                    else                check_path("R1", s, feed_exp(d));
                    chk("R3 ref", int'(ref_en), cen);
                    chk("R9 flag", int'(stat_byte[5]), (s == 7) ? 1 : 0);
                end
            end
        end

        // R10: auxiliary selects, all pairs
        for (int t = 0; t < 8; t++) begin
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                txt_sel = 3'(t); pip_sel = 3'(p);
                @(posedge clk);
                #1;
                chk("R10 txt", int'(txt_out), (t == 1) ? 0 : t);
                chk("R10 pip", int'(pip_out), (p == 1) ? 0 : p);
            end
        end

        // R6: auto Y/C amplitude comparison, both inputs, tie
        for (int in4 = 0; in4 < 2; in4++) begin
            auto_case("R6 c>y", in4, 0, 10, 20, 1);
            auto_case("R6 c<y", in4, 0, 20, 10, 1);
            auto_case("R6 tie", in4, 0, 15, 15, 0);
        end

        // R7: auto comb, threshold boundaries and combable
        for (int in4 = 0; in4 < 2; in4++) begin
            auto_case("R7 c@thr", in4, 1, 40, THR, 1);
            auto_case("R7 comb", in4, 1, THR, THR - 1, 1);
            auto_case("R7 nocomb", in4, 1, 40, 3, 0);
            auto_case("R7 noburst", in4, 1, THR - 1, THR - 1, 1);
        end

        // R8: hold against amplitude changes, re-evaluate on std_id change
        auto_case("R8 setup", 0, 0, 5, 30, 0);
        @(negedge clk);
        amp_y3 = 6'd40; amp_c3 = 6'd1;
        repeat (5) @(posedge clk);
        #1;
        check_path("R8 held", 4, 5);
        @(negedge clk);
        std_id = 2'd1;
        repeat (3) @(posedge clk);
        #1;
        check_path("R8 std change", 3, 4);

        // R8: code rewrite with identification not valid holds, then decides
        @(negedge clk);
        std_valid = 1'b0;
        src_code = 4'b1110;
        amp_y4 = 6'd2; amp_c4 = 6'd50;
        repeat (5) @(posedge clk);
        #1;
        check_path("R8 pending", 5, 6);
        @(negedge clk);
        std_valid = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_path("R8 decided", 6, 7);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule